// File: doc/BRIEF.md
# Serial Bus PHY Status and Control Register Bank

This block is the small register bank that sits inside the physical layer of a serial bus. It keeps four sticky event flags: loop detect, cable power failure, state timeout and port event. It also holds a handful of control bits and two selector fields. The link reaches it through a plain address/data interface. A write takes effect at the next clock edge. A read delivers its data one cycle after the request. Flags are raised by hardware event inputs and are cleared by the host, which writes a one to the flag's bit position.

The bank separates two reset classes. The synchronous system reset `rst` zeroes every register. A bus reset (`bus_reset`) clears only the pending short-reset request, and leaves flags, enables and selectors as they were. When the loop flag and the watchdog control bit are both set while the link is inactive, the block raises a wake-up request toward the link layer.

Address map: 0 holds the control bits, 1 holds the flags, 2 holds the selectors. Addresses 3 to 7 are unused. Addresses 8 to 15 belong to the paged space, which is served elsewhere. All of these read as zero here.

Top module: `phy_stat_bank`

## Requirements
- R1: After system reset, all flags, control bits, selectors, `reg_rdata` and `link_wake_req` are zero.
- R2: A read issued in cycle N presents data in cycle N+1, and `reg_rdata` is zero in every cycle that follows a cycle without a read. Address 0 reads {4'b0, multi_en, accel_en, watchdog, short_reset}. Address 1 reads {4'b0, port_event, state_timeout, power_fail, loop}. Address 2 reads {port_sel[3:0], 1'b0, page_sel[2:0]}. Any other address reads zero.
- R3: A one-cycle pulse on `tree_id_timeout` sets the loop flag (`evt_flags[0]`). Writing zero to bit 0 of address 1 leaves it set. Writing one to that bit clears it.
- R4: A high-to-low transition of `cable_pwr_sense` sets the power-fail flag (`evt_flags[1]`). Holding the input low after it has been cleared sets nothing, and a rising edge sets nothing.
- R5: A pulse on `state_timeout` sets `evt_flags[2]`. A one written to bit 2 of address 1 clears it.
- R6: A change in the connected, disabled or fault input of a port whose `port_int_en` bit is one sets `evt_flags[3]`. A change in that port's bias input sets the flag only when its `port_bias_rpt_en` bit is one. Changes on ports without the interrupt enable set nothing.
- R7: A `port_resume` pulse on any port sets `evt_flags[3]` when the watchdog bit (address 0, bit 1) is one, and has no effect when the watchdog bit is zero.
- R8: When a set event and a write-one-to-clear reach the same flag in the same cycle, the flag ends up set.
- R9: Writing one to bit 0 of address 0 raises `short_reset_req` at the next edge. It stays high until a `bus_reset` pulse clears it.
- R10: A `bus_reset` pulse leaves `accel_en` (address 0 bit 2), `multi_en` (bit 3), `page_sel`, `port_sel`, the watchdog bit and all flags unchanged.
- R11: `link_wake_req` is high in the cycle after one in which the loop flag and the watchdog bit are both one and `link_active` is low, and low otherwise. This covers both the case where the link was already inactive and the case where it goes inactive later.
- R12: A register write in cycle N shows on the control and selector outputs in cycle N+1. Bit 3 of address 2 is reserved, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| bus_reset | input | 1 | Bus reset pulse |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, one cycle after `reg_rd` |
| tree_id_timeout | input | 1 | Arbitration timeout during tree identification start |
| cable_pwr_sense | input | 1 | Cable power sense level |
| state_timeout | input | 1 | State timeout event |
| port_connected | input | NP | Per-port connected status |
| port_bias | input | NP | Per-port bias status |
| port_disabled | input | NP | Per-port disabled status |
| port_fault | input | NP | Per-port fault status |
| port_resume | input | NP | Per-port resume start pulse |
| port_int_en | input | NP | Per-port interrupt enable |
| port_bias_rpt_en | input | NP | Per-port bias change reporting enable |
| link_active | input | 1 | Link layer is active |
| evt_flags | output | 4 | Flags {port_event, state_timeout, power_fail, loop} |
| short_reset_req | output | 1 | Request for a short arbitrated bus reset |
| accel_en | output | 1 | Accelerated arbitration enable |
| multi_en | output | 1 | Multispeed concatenation enable |
| page_sel | output | 3 | Page selector for addresses 8 to 15 |
| port_sel | output | 4 | Port selector for per-port accesses |
| link_wake_req | output | 1 | Request to activate the link layer |

## Verification
The hardest situation to reach is a hardware set and a host clear landing on the same flag in the same clock cycle. The bench does this by driving the event pulse and the write-one-to-clear from the same falling edge, so that both are sampled at one rising edge. A second difficult case is an input that stays low after its edge has been consumed. The bench clears the power-fail flag while the sense input is still low, then watches the flag over several cycles, and only afterwards releases the input. The port-event tests toggle masked and unmasked status inputs one port at a time, so that each mask path is isolated.

// File: rtl/phy_stat_pkg.sv
package phy_stat_pkg;

    localparam int ADDR_W    = 4;
    localparam int DATA_W    = 8;
    localparam int PAGE_W    = 3;
    localparam int PSEL_W    = 4;
    localparam int NUM_FLAGS = 4;

    localparam int FLG_LOOP = 0;
    localparam int FLG_PWR  = 1;
    localparam int FLG_STO  = 2;
    localparam int FLG_PEV  = 3;

    localparam logic [ADDR_W-1:0] ADR_CTRL  = 4'h0;
    localparam logic [ADDR_W-1:0] ADR_FLAGS = 4'h1;
    localparam logic [ADDR_W-1:0] ADR_SEL   = 4'h2;

    typedef struct packed {
        logic multi_en;
        logic accel_en;
        logic wd_en;
        logic short_rst;
    } ctrl_t;

    typedef struct packed {
        logic [PSEL_W-1:0] port_sel;
        logic              rsvd;
        logic [PAGE_W-1:0] page_sel;
    } sel_t;

    function automatic logic [DATA_W-1:0] pack_ctrl(input ctrl_t c);
        return {{(DATA_W-4){1'b0}}, c};
    endfunction

    function automatic logic [DATA_W-1:0] pack_flags(input logic [NUM_FLAGS-1:0] f);
        return {{(DATA_W-NUM_FLAGS){1'b0}}, f};
    endfunction

    function automatic sel_t unpack_sel(input logic [DATA_W-1:0] d);
        sel_t s;
        s          = sel_t'(d);
        s.rsvd     = 1'b0;
        return s;
    endfunction

endpackage

// File: rtl/phy_pwr_fall.sv
module phy_pwr_fall (
    input  logic clk,
    input  logic rst,
    input  logic sense,
    output logic fall
);
    logic sense_q;

    // The registered copy follows the input even during reset, so a level
    // that is already low when reset is released produces no edge.
    always_ff @(posedge clk) begin
        sense_q <= sense;
    end

    assign fall = sense_q & ~sense & ~rst;
endmodule

// File: rtl/phy_port_watch.sv
module phy_port_watch #(
    parameter int NP = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NP-1:0] conn,
    input  logic [NP-1:0] bias,
    input  logic [NP-1:0] dis,
    input  logic [NP-1:0] fault,
    input  logic [NP-1:0] resume,
    input  logic [NP-1:0] int_en,
    input  logic [NP-1:0] bias_rpt_en,
    input  logic          wd_en,
    output logic          hit
);
    logic [NP-1:0] conn_q, bias_q, dis_q, fault_q;
    logic [NP-1:0] chg;

    always_ff @(posedge clk) begin
        conn_q  <= conn;
        bias_q  <= bias;
        dis_q   <= dis;
        fault_q <= fault;
    end

    for (genvar i = 0; i < NP; i++) begin : g_port
        logic base_chg;
        logic bias_chg;
        assign base_chg = (conn[i] ^ conn_q[i]) | (dis[i] ^ dis_q[i]) |
                          (fault[i] ^ fault_q[i]);
        assign bias_chg = bias_rpt_en[i] & (bias[i] ^ bias_q[i]);
        assign chg[i]   = int_en[i] & (base_chg | bias_chg);
    end

    assign hit = ~rst & ((|chg) | (wd_en & (|resume)));
endmodule

// File: rtl/phy_sticky_flags.sv
module phy_sticky_flags #(
    parameter int NF = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NF-1:0] set,
    input  logic [NF-1:0] clr,
    output logic [NF-1:0] q
);
    for (genvar k = 0; k < NF; k++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                q[k] <= 1'b0;
            else if (set[k])
                q[k] <= 1'b1;
            else if (clr[k])
                q[k] <= 1'b0;
        end
    end
endmodule

// File: rtl/phy_ctrl_regs.sv
module phy_ctrl_regs
    import phy_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_reset,
    input  logic              wr_ctrl,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wdata,
    output ctrl_t             ctrl,
    output sel_t              sel
);
    ctrl_t wr_val;
    assign wr_val = ctrl_t'(wdata[3:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl.multi_en <= wr_val.multi_en;
                ctrl.accel_en <= wr_val.accel_en;
                ctrl.wd_en    <= wr_val.wd_en;
            end
            if (bus_reset)
                ctrl.short_rst <= 1'b0;
            else if (wr_ctrl)
                ctrl.short_rst <= wr_val.short_rst;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            sel <= '0;
        else if (wr_sel)
            sel <= unpack_sel(wdata);
    end
endmodule

// File: rtl/phy_stat_bank.sv
module phy_stat_bank
    import phy_stat_pkg::*;
#(
    parameter int NP = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_reset,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [3:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              tree_id_timeout,
    input  logic              cable_pwr_sense,
    input  logic              state_timeout,
    input  logic [NP-1:0]     port_connected,
    input  logic [NP-1:0]     port_bias,
    input  logic [NP-1:0]     port_disabled,
    input  logic [NP-1:0]     port_fault,
    input  logic [NP-1:0]     port_resume,
    input  logic [NP-1:0]     port_int_en,
    input  logic [NP-1:0]     port_bias_rpt_en,
    input  logic              link_active,
    output logic [3:0]        evt_flags,
    output logic              short_reset_req,
    output logic              accel_en,
    output logic              multi_en,
    output logic [2:0]        page_sel,
    output logic [3:0]        port_sel,
    output logic              link_wake_req
);
    ctrl_t                 ctrl;
    sel_t                  sel;
    logic                  wd_en;
    logic                  pwr_fall;
    logic                  port_hit;
    logic [NUM_FLAGS-1:0]  flag_set;
    logic [NUM_FLAGS-1:0]  flag_clr;
    logic [NUM_FLAGS-1:0]  flags;
    logic                  wr_ctrl, wr_sel, wr_flags;

    assign wr_ctrl  = reg_wr && (reg_addr == ADR_CTRL);
    assign wr_sel   = reg_wr && (reg_addr == ADR_SEL);
    assign wr_flags = reg_wr && (reg_addr == ADR_FLAGS);

    phy_ctrl_regs u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .bus_reset (bus_reset),
        .wr_ctrl   (wr_ctrl),
        .wr_sel    (wr_sel),
        .wdata     (reg_wdata),
        .ctrl      (ctrl),
        .sel       (sel)
    );

    assign wd_en = ctrl.wd_en;

    phy_pwr_fall u_pwr (
        .clk   (clk),
        .rst   (rst),
        .sense (cable_pwr_sense),
        .fall  (pwr_fall)
    );

    phy_port_watch #(.NP(NP)) u_ports (
        .clk         (clk),
        .rst         (rst),
        .conn        (port_connected),
        .bias        (port_bias),
        .dis         (port_disabled),
        .fault       (port_fault),
        .resume      (port_resume),
        .int_en      (port_int_en),
        .bias_rpt_en (port_bias_rpt_en),
        .wd_en       (wd_en),
        .hit         (port_hit)
    );

    always_comb begin
        flag_set           = '0;
        flag_set[FLG_LOOP] = tree_id_timeout;
        flag_set[FLG_PWR]  = pwr_fall;
        flag_set[FLG_STO]  = state_timeout;
        flag_set[FLG_PEV]  = port_hit;
        flag_clr           = wr_flags ? reg_wdata[NUM_FLAGS-1:0] : '0;
    end

    phy_sticky_flags #(.NF(NUM_FLAGS)) u_flags (
        .clk (clk),
        .rst (rst),
        .set (flag_set),
        .clr (flag_clr),
        .q   (flags)
    );

    // Registered read port, zero when idle or for an unmapped address.
    always_ff @(posedge clk) begin
        if (rst || !reg_rd) begin
            reg_rdata <= '0;
        end else begin
            unique case (reg_addr)
                ADR_CTRL:  reg_rdata <= pack_ctrl(ctrl);
                ADR_FLAGS: reg_rdata <= pack_flags(flags);
                ADR_SEL:   reg_rdata <= sel;
                default:   reg_rdata <= '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            link_wake_req <= 1'b0;
        else
            link_wake_req <= flags[FLG_LOOP] & wd_en & ~link_active;
    end

    assign evt_flags       = flags;
    assign short_reset_req = ctrl.short_rst;
    assign accel_en        = ctrl.accel_en;
    assign multi_en        = ctrl.multi_en;
    assign page_sel        = sel.page_sel;
    assign port_sel        = sel.port_sel;
endmodule

// File: rtl/phy_stat_bank_chk.sv
module phy_stat_bank_chk #(
    parameter int NP = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          bus_reset,
    input logic          reg_wr,
    input logic          reg_rd,
    input logic [3:0]    reg_addr,
    input logic [7:0]    reg_wdata,
    input logic [7:0]    reg_rdata,
    input logic          tree_id_timeout,
    input logic          state_timeout,
    input logic [NP-1:0] port_connected,
    input logic [NP-1:0] port_int_en,
    input logic          link_active,
    input logic [3:0]    evt_flags,
    input logic          short_reset_req,
    input logic          accel_en,
    input logic          multi_en,
    input logic [2:0]    page_sel,
    input logic [3:0]    port_sel,
    input logic          link_wake_req,
    input logic          wd_en
);
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (evt_flags == 4'h0 && !short_reset_req && !accel_en && !multi_en &&
                 page_sel == 3'd0 && port_sel == 4'd0 && !link_wake_req));

    p_idle_rdata_r2: assert property (@(posedge clk) disable iff (rst)
        !reg_rd |=> (reg_rdata == 8'h00));

    p_loop_set_r3: assert property (@(posedge clk) disable iff (rst)
        tree_id_timeout |=> evt_flags[0]);

    p_sto_set_r5: assert property (@(posedge clk) disable iff (rst)
        state_timeout |=> evt_flags[2]);

    p_port_chg_r6: assert property (@(posedge clk) disable iff (rst)
        (((port_connected ^ $past(port_connected)) & port_int_en) != '0) |=> evt_flags[3]);

    for (genvar k = 0; k < 4; k++) begin : g_sticky
        p_flag_sticky_r8: assert property (@(posedge clk) disable iff (rst)
            (evt_flags[k] && !(reg_wr && reg_addr == 4'h1 && reg_wdata[k])) |=> evt_flags[k]);
    end

    p_short_clear_r9: assert property (@(posedge clk) disable iff (rst)
        bus_reset |=> !short_reset_req);

    p_busrst_keep_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_reset && !reg_wr) |=> ($stable(accel_en) && $stable(multi_en) &&
                                    $stable(page_sel) && $stable(port_sel)));

    p_wake_on_r11: assert property (@(posedge clk) disable iff (rst)
        (evt_flags[0] && wd_en && !link_active) |=> link_wake_req);

    p_wake_off_r11: assert property (@(posedge clk) disable iff (rst)
        !(evt_flags[0] && wd_en && !link_active) |=> !link_wake_req);
endmodule

bind phy_stat_bank phy_stat_bank_chk #(.NP(NP)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .bus_reset       (bus_reset),
    .reg_wr          (reg_wr),
    .reg_rd          (reg_rd),
    .reg_addr        (reg_addr),
    .reg_wdata       (reg_wdata),
    .reg_rdata       (reg_rdata),
    .tree_id_timeout (tree_id_timeout),
    .state_timeout   (state_timeout),
    .port_connected  (port_connected),
    .port_int_en     (port_int_en),
    .link_active     (link_active),
    .evt_flags       (evt_flags),
    .short_reset_req (short_reset_req),
    .accel_en        (accel_en),
    .multi_en        (multi_en),
    .page_sel        (page_sel),
    .port_sel        (port_sel),
    .link_wake_req   (link_wake_req),
    .wd_en           (wd_en)
);

// File: tb/tb_phy_stat_bank.sv
`timescale 1ns/1ps
module tb_phy_stat_bank;
    localparam int NP = 3;

    logic          clk = 1'b0;
    logic          rst;
    logic          bus_reset;
    logic          reg_wr, reg_rd;
    logic [3:0]    reg_addr;
    logic [7:0]    reg_wdata;
    logic [7:0]    reg_rdata;
    logic          tree_id_timeout, cable_pwr_sense, state_timeout;
    logic [NP-1:0] port_connected, port_bias, port_disabled, port_fault;
    logic [NP-1:0] port_resume, port_int_en, port_bias_rpt_en;
    logic          link_active;
    logic [3:0]    evt_flags;
    logic          short_reset_req, accel_en, multi_en;
    logic [2:0]    page_sel;
    logic [3:0]    port_sel;
    logic          link_wake_req;

    int checks   = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    phy_stat_bank #(.NP(NP)) dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic do_read(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic pulse_loop();
        @(negedge clk); tree_id_timeout = 1'b1;
        @(negedge clk); tree_id_timeout = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R1", evt_flags, 4'h0, "flags after reset");
        chk("R1", {short_reset_req, accel_en, multi_en, link_wake_req}, 4'h0, "ctrl outs after reset");
        chk("R1", {page_sel, port_sel}, 7'h0, "selectors after reset");
        chk("R1", reg_rdata, 8'h00, "rdata after reset");
        do_read(4'h1, d); chk("R1", d, 8'h00, "flags read after reset");
    endtask

    task automatic t_regmap();
        logic [7:0] d;
        do_write(4'h0, 8'h0E);
        chk("R12", {multi_en, accel_en, short_reset_req}, 3'b110, "ctrl outputs next cycle");
        do_write(4'h2, 8'hAD);
        chk("R12", page_sel, 3'd5, "page_sel");
        chk("R12", port_sel, 4'hA, "port_sel");
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = 4'h0;
        chk("R2", reg_rdata, 8'h00, "rdata before read edge");
        @(negedge clk);
        reg_rd = 1'b0;
        chk("R2", reg_rdata, 8'h0E, "ctrl read one cycle later");
        @(negedge clk);
        chk("R2", reg_rdata, 8'h00, "rdata idle after read");
        do_read(4'h2, d); chk("R12", d, 8'hA5, "sel read, reserved bit ignored");
        do_read(4'h9, d); chk("R2", d, 8'h00, "paged address reads zero");
        do_read(4'h3, d); chk("R2", d, 8'h00, "unused address reads zero");
        do_write(4'h0, 8'h00);
        do_write(4'h2, 8'h00);
    endtask

    task automatic t_loop();
        logic [7:0] d;
        pulse_loop();
        chk("R3", evt_flags[0], 1'b1, "loop set by timeout");
        do_write(4'h1, 8'h00);
        chk("R3", evt_flags[0], 1'b1, "loop survives zero write");
        do_read(4'h1, d); chk("R3", d, 8'h01, "loop read bit0");
        do_write(4'h1, 8'h01);
        chk("R3", evt_flags[0], 1'b0, "loop cleared by one write");
    endtask

    task automatic t_pwr();
        @(negedge clk); cable_pwr_sense = 1'b0;
        @(negedge clk);
        chk("R4", evt_flags[1], 1'b1, "power fail on falling edge");
        do_write(4'h1, 8'h02);
        cyc(4);
        chk("R4", evt_flags[1], 1'b0, "held low does not re-set");
        @(negedge clk); cable_pwr_sense = 1'b1;
        cyc(2);
        chk("R4", evt_flags[1], 1'b0, "rising edge does not set");
    endtask

    task automatic t_sto();
        @(negedge clk); state_timeout = 1'b1; bus_reset = 1'b1;
        @(negedge clk); state_timeout = 1'b0; bus_reset = 1'b0;
        chk("R5", evt_flags[2], 1'b1, "state timeout set");
        do_write(4'h1, 8'h04);
        chk("R5", evt_flags[2], 1'b0, "state timeout cleared");
    endtask

    task automatic t_port();
        port_int_en = 3'b011; port_bias_rpt_en = 3'b001;
        cyc(1);
        @(negedge clk); port_connected[2] = ~port_connected[2];
        cyc(2);
        chk("R6", evt_flags[3], 1'b0, "masked port ignored");
        @(negedge clk); port_bias[1] = ~port_bias[1];
        cyc(2);
        chk("R6", evt_flags[3], 1'b0, "bias change without reporting ignored");
        @(negedge clk); port_bias[0] = ~port_bias[0];
        @(negedge clk);
        chk("R6", evt_flags[3], 1'b1, "bias change with reporting");
        do_write(4'h1, 8'h08);
        @(negedge clk); port_fault[1] = 1'b1;
        @(negedge clk);
        chk("R6", evt_flags[3], 1'b1, "fault change on enabled port");
        do_write(4'h1, 8'h08);
        @(negedge clk); port_disabled[0] = 1'b1;
        @(negedge clk);
        chk("R6", evt_flags[3], 1'b1, "disabled change on enabled port");
        do_write(4'h1, 8'h08);
        chk("R6", evt_flags[3], 1'b0, "port event cleared");
    endtask

    task automatic t_resume();
        @(negedge clk); port_resume[2] = 1'b1;
        @(negedge clk); port_resume[2] = 1'b0;
        chk("R7", evt_flags[3], 1'b0, "resume without watchdog ignored");
        do_write(4'h0, 8'h02);
        @(negedge clk); port_resume[1] = 1'b1;
        @(negedge clk); port_resume[1] = 1'b0;
        chk("R7", evt_flags[3], 1'b1, "resume with watchdog sets");
        do_write(4'h1, 8'h08);
        do_write(4'h0, 8'h00);
    endtask

    task automatic t_setwins();
        pulse_loop();
        @(negedge clk);
        tree_id_timeout = 1'b1; reg_wr = 1'b1; reg_addr = 4'h1; reg_wdata = 8'h01;
        @(negedge clk);
        tree_id_timeout = 1'b0; reg_wr = 1'b0;
        chk("R8", evt_flags[0], 1'b1, "set beats clear");
        do_write(4'h1, 8'h01);
        chk("R8", evt_flags[0], 1'b0, "later clear works");
    endtask

    task automatic t_short();
        do_write(4'h0, 8'h01);
        chk("R9", short_reset_req, 1'b1, "short reset requested");
        cyc(3);
        chk("R9", short_reset_req, 1'b1, "request held");
        @(negedge clk); bus_reset = 1'b1;
        @(negedge clk); bus_reset = 1'b0;
        chk("R9", short_reset_req, 1'b0, "bus reset clears request");
    endtask

    task automatic t_busrst();
        do_write(4'h0, 8'h0E);
        do_write(4'h2, 8'h3B);
        pulse_loop();
        @(negedge clk); bus_reset = 1'b1;
        @(negedge clk); bus_reset = 1'b0;
        chk("R10", {multi_en, accel_en}, 2'b11, "enables kept");
        chk("R10", {page_sel, port_sel}, {3'd3, 4'd3}, "selectors kept");
        chk("R10", evt_flags[0], 1'b1, "flag kept");
        do_write(4'h1, 8'h01);
        do_write(4'h0, 8'h00);
        do_write(4'h2, 8'h00);
    endtask

    task automatic t_wake();
        link_active = 1'b1;
        do_write(4'h0, 8'h02);
        pulse_loop();
        cyc(2);
        chk("R11", link_wake_req, 1'b0, "no wake while link active");
        @(negedge clk); link_active = 1'b0;
        @(negedge clk);
        chk("R11", link_wake_req, 1'b1, "wake when link goes inactive");
        do_write(4'h1, 8'h01);
        @(negedge clk);
        chk("R11", link_wake_req, 1'b0, "wake drops after clear");
        pulse_loop();
        @(negedge clk);
        chk("R11", link_wake_req, 1'b1, "wake with link already inactive");
        do_write(4'h0, 8'h00);
        @(negedge clk);
        chk("R11", link_wake_req, 1'b0, "wake drops without watchdog");
        do_write(4'h1, 8'h01);
        link_active = 1'b1;
    endtask

    initial begin
        rst = 1'b1; bus_reset = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0;
        reg_addr = '0; reg_wdata = '0;
        tree_id_timeout = 1'b0; cable_pwr_sense = 1'b1; state_timeout = 1'b0;
        port_connected = '0; port_bias = '0; port_disabled = '0; port_fault = '0;
        port_resume = '0; port_int_en = '0; port_bias_rpt_en = '0; link_active = 1'b1;
        cyc(4);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_loop();
        t_pwr();
        t_sto();
        t_port();
        t_resume();
        t_setwins();
        t_short();
        t_busrst();
        t_wake();
        cyc(2);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule